// File: doc/BRIEF.md
# Truncated Integer Powering Unit

This block raises a short unsigned fraction to the second or third power and returns only the upper bits of the result. Its purpose is to feed a coefficient multiplier in a piecewise-polynomial function evaluator. Such a multiplier needs only a rough copy of the power, so full precision is not required. The input code `x` of `IN_W` bits is widened by one bit before powering. That extra least significant bit is always one. The unit therefore raises the value at the centre of the input code's range, and the error from the input's reduced width is balanced around zero.

Partial products are built only when their weight is at or above `2^-MU`. The lower ones are never built. A constant fixed at elaboration time stands in for their average contribution: it is half of their largest possible sum, rounded to `2^-MU`. The kept sum plus this constant is then cut down to `LAMBDA` bits. The squarer forms each cross product once and gives it doubled weight. The cuber groups repeated index triples and adds each group with weight 1, 3 or 6.

Data enters and leaves through valid/ready handshakes. A word moves across a port on any clock edge where that port's valid and ready are both high. When `REG_OUT` is 1, a single-entry output register sits between the two ports. It accepts a new word whenever it is empty or its content is leaving in the same cycle. A stalled output word stays exactly as it is until it is taken. When `REG_OUT` is 0, the path is combinational and the handshake passes straight through.

Top module: `trunc_power_unit`

## Requirements
- R1: An input code `x` is raised as the fraction v = (2x+1) / 2^(IN_W+1). The appended bit is always one, so input 0 gives v = 2^-(IN_W+1), not zero.
- R2: With r = out_data / 2^LAMBDA, the result satisfies |r - v^K| <= s/2 + 2^-MU + 2^-LAMBDA. Here s is the largest sum of the omitted terms, taken with every bit of v set to one.
- R3: Parameter K = 3 selects cubing. Any other value selects squaring.
- R4: An ordered index tuple (bit positions counted from 1 at weight 2^-1) is omitted exactly when the sum of its indices exceeds MU. When MU >= K*(IN_W+1), nothing is omitted, the constant is zero, and out_data = floor(v^K * 2^LAMBDA) exactly.
- R5: The constant added to the kept sum is s/2 rounded to the nearest multiple of 2^-MU. It is computed from the parameters at elaboration.
- R6: If the kept sum plus the constant reaches 1.0, out_data saturates to all ones and never wraps to a small value.
- R7: With REG_OUT = 1, in_ready is high whenever the output register is empty or out_ready is high. An accepted word is presented on the next cycle. While out_valid is high and out_ready is low, out_valid and out_data hold.
- R8: While rst_n is low, out_valid is low. It stays low on the first cycle after reset until a word is accepted.
- R9: With REG_OUT = 0, out_valid equals in_valid and in_ready equals out_ready in every cycle. out_data is the result for the present in_data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Unit can take the input word |
| in_data | input | IN_W | Reduced input code x |
| out_valid | output | 1 | Result word present |
| out_ready | input | 1 | Consumer can take the result |
| out_data | output | LAMBDA | Truncated power, fraction of 2^LAMBDA |

## Verification
The squaring setup runs every one of its input codes, with dropped terms below 2^-12. Each result is compared with the exact square of the centred fraction against the error bound. This separates a correct truncation from a lost compensation, a wrong cross-product weight or a missing half-ulp bit. A second instance cubes every code with no terms dropped. It must match the exact floored cube bit for bit, which exposes any wrong multiplicity in the cube grouping. Both instances run under an irregular out_ready pattern. The pattern shows whether stalled words hold and whether the registered and pass-through handshakes each keep their own rules.

// File: rtl/powu_pkg.sv
package powu_pkg;

  // Largest sum of the omitted terms, halved and rounded to 2^-mu.
  // The sum is formed over ordered index tuples whose index sum exceeds mu.
  function automatic longint powu_comp(input int k, input int n, input int mu);
    longint s;
    int     full;
    int     sh;
    s    = 0;
    full = k * n;
    for (int i = 1; i <= n; i++) begin
      for (int j = 1; j <= n; j++) begin
        if (k == 3) begin
          for (int l = 1; l <= n; l++) begin
            if (i + j + l > mu) s = s + (longint'(1) << (full - i - j - l));
          end
        end else begin
          if (i + j > mu) s = s + (longint'(1) << (full - i - j));
        end
      end
    end
    if (mu >= full) return 0;
    sh = full + 1 - mu;
    return (s + (longint'(1) << (sh - 1))) >> sh;
  endfunction

endpackage

// File: rtl/powu_sq_pp.sv
module powu_sq_pp #(
  parameter int N     = 8,
  parameter int MU    = 12,
  parameter int ACC_W = 14
) (
  input  logic [N-1:0]     v,
  output logic [ACC_W-1:0] kept
);
  // Bit i (from 1) of v sits at v[N-i] with weight 2^-i.
  always_comb begin
    kept = '0;
    for (int i = 1; i <= N; i++) begin
      // diagonal: v_i * v_i = v_i at weight 2^-2i
      if (2 * i <= MU) kept = kept + (ACC_W'(v[N-i]) << (MU - 2 * i));
      for (int j = i + 1; j <= N; j++) begin
        // cross product counted once at doubled weight
        if (i + j <= MU) kept = kept + (ACC_W'(v[N-i] & v[N-j]) << (MU - i - j + 1));
      end
    end
  end
endmodule

// File: rtl/powu_cu_pp.sv
module powu_cu_pp #(
  parameter int N     = 8,
  parameter int MU    = 12,
  parameter int ACC_W = 14
) (
  input  logic [N-1:0]     v,
  output logic [ACC_W-1:0] kept
);
  always_comb begin
    kept = '0;
    for (int i = 1; i <= N; i++) begin
      for (int j = i; j <= N; j++) begin
        for (int l = j; l <= N; l++) begin
          if (i + j + l <= MU) begin
            if (i == j && j == l) begin
              kept = kept + (ACC_W'(v[N-i]) << (MU - 3 * i));
            end else if (i == j || j == l) begin
              // three orderings: weight x3 as x2 plus x1
              kept = kept + (ACC_W'(v[N-i] & v[N-l]) << (MU - i - j - l))
                          + (ACC_W'(v[N-i] & v[N-l]) << (MU - i - j - l + 1));
            end else begin
              // six orderings: weight x6 as x4 plus x2
              kept = kept + (ACC_W'(v[N-i] & v[N-j] & v[N-l]) << (MU - i - j - l + 1))
                          + (ACC_W'(v[N-i] & v[N-j] & v[N-l]) << (MU - i - j - l + 2));
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/powu_fold.sv
module powu_fold #(
  parameter int               MU     = 12,
  parameter int               LAMBDA = 10,
  parameter int               ACC_W  = 14,
  parameter logic [ACC_W-1:0] COMP   = '0
) (
  input  logic [ACC_W-1:0]  kept,
  output logic [LAMBDA-1:0] res
);
  logic [ACC_W:0] total;
  logic           ovf;

  always_comb begin
    total = {1'b0, kept} + {1'b0, COMP};
    ovf   = |total[ACC_W:MU];
    res   = ovf ? {LAMBDA{1'b1}} : total[MU-1 -: LAMBDA];
  end
endmodule

// File: rtl/powu_stage.sv
module powu_stage #(
  parameter int W       = 10,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q
);
  generate
    if (REG_OUT) begin : g_reg
      logic         vld;
      logic [W-1:0] dat;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld <= 1'b0;
          dat <= '0;
        end else if (in_ready) begin
          vld <= in_valid;
          if (in_valid) dat <= d;
        end
      end
      assign in_ready  = !vld || out_ready;
      assign out_valid = vld;
      assign q         = dat;
    end else begin : g_pass
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign q         = d;
    end
  endgenerate
endmodule

// File: rtl/trunc_power_unit.sv
module trunc_power_unit
  import powu_pkg::*;
#(
  parameter int K       = 2,
  parameter int IN_W    = 7,
  parameter int MU      = 12,
  parameter int LAMBDA  = 10,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IN_W-1:0]   in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LAMBDA-1:0] out_data
);
  localparam int               N     = IN_W + 1;
  localparam int               ACC_W = MU + 2;
  localparam logic [ACC_W-1:0] COMP  = ACC_W'(powu_comp(K, N, MU));

  logic [N-1:0]      v;
  logic [ACC_W-1:0]  kept;
  logic [LAMBDA-1:0] res;

  // centred input: implicit half-ulp bit appended
  assign v = {in_data, 1'b1};

  generate
    if (K == 3) begin : g_cube
      powu_cu_pp #(.N(N), .MU(MU), .ACC_W(ACC_W)) u_pp (.v(v), .kept(kept));
    end else begin : g_square
      powu_sq_pp #(.N(N), .MU(MU), .ACC_W(ACC_W)) u_pp (.v(v), .kept(kept));
    end
  endgenerate

  powu_fold #(.MU(MU), .LAMBDA(LAMBDA), .ACC_W(ACC_W), .COMP(COMP)) u_fold (
    .kept(kept),
    .res (res)
  );

  powu_stage #(.W(LAMBDA), .REG_OUT(REG_OUT)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .d        (res),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .q        (out_data)
  );
endmodule

// File: rtl/powu_checker.sv
module powu_checker #(
  parameter int LAMBDA  = 10,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [LAMBDA-1:0] out_data
);
  generate
    if (REG_OUT) begin : g_reg_chk
      p_reset_idle_r8: assert property (@(posedge clk) !rst_n |=> !out_valid);
      p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
      p_empty_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);
      p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);
    end else begin : g_pass_chk
      p_pass_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == in_valid);
      p_pass_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == out_ready);
    end
  endgenerate
endmodule

bind trunc_power_unit powu_checker #(.LAMBDA(LAMBDA), .REG_OUT(REG_OUT)) u_powu_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data)
);

// File: tb/tb_trunc_power_unit.sv
module tb_trunc_power_unit;
  localparam int SQ_W = 7, SQ_MU = 12, SQ_L = 10;
  localparam int CU_W = 5, CU_MU = 18, CU_L = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic rst_n;
  logic sq_iv, sq_ir, sq_ov, sq_or;
  logic [SQ_W-1:0] sq_id;
  logic [SQ_L-1:0] sq_od;
  logic cu_iv, cu_ir, cu_ov, cu_or;
  logic [CU_W-1:0] cu_id;
  logic [CU_L-1:0] cu_od;

  trunc_power_unit #(.K(2), .IN_W(SQ_W), .MU(SQ_MU), .LAMBDA(SQ_L), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(sq_iv), .in_ready(sq_ir), .in_data(sq_id),
    .out_valid(sq_ov), .out_ready(sq_or), .out_data(sq_od));

  trunc_power_unit #(.K(3), .IN_W(CU_W), .MU(CU_MU), .LAMBDA(CU_L), .REG_OUT(1'b0)) dut_cube (
    .clk(clk), .rst_n(rst_n), .in_valid(cu_iv), .in_ready(cu_ir), .in_data(cu_id),
    .out_valid(cu_ov), .out_ready(cu_or), .out_data(cu_od));

  int checks = 0;
  int errors = 0;
  logic [SQ_W-1:0] q_sq[$];
  logic [CU_W-1:0] q_cu[$];
  longint s_sq;
  bit stalled_prev = 1'b0;
  logic [SQ_L-1:0] stalled_data;
  logic [15:0] lfsr = 16'hACE1;

  task automatic report(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_sq(input logic [SQ_W-1:0] x);
    @(negedge clk);
    sq_iv = 1'b1; sq_id = x;
    #1;
    while (!sq_ir) begin @(negedge clk); #1; end
    q_sq.push_back(x);
  endtask

  task automatic send_cu(input logic [CU_W-1:0] x);
    @(negedge clk);
    cu_iv = 1'b1; cu_id = x;
    #1;
    while (!cu_ir) begin @(negedge clk); #1; end
    q_cu.push_back(x);
  endtask

  // irregular consumer back-pressure
  initial begin
    sq_or = 1'b1; cu_or = 1'b1;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sq_or = lfsr[0] | lfsr[3];
      cu_or = lfsr[5] | lfsr[8];
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      // R9: pass-through handshake of the cube instance
      report(cu_ov == cu_iv && cu_ir == cu_or, "R9", longint'({cu_ov, cu_ir}), longint'({cu_iv, cu_or}));
      // R7: stalled word holds
      if (stalled_prev) report(sq_ov && sq_od == stalled_data, "R7", longint'(sq_od), longint'(stalled_data));
      stalled_prev = sq_ov && !sq_or;
      stalled_data = sq_od;
      if (sq_ov && sq_or) begin
        if (q_sq.size() == 0) report(1'b0, "R7", 1, 0);
        else begin
          logic [SQ_W-1:0] x;
          longint e, r, d2, b2;
          x  = q_sq.pop_front();
          e  = (2 * longint'(x) + 1) * (2 * longint'(x) + 1);  // R1: centred value, units 2^-16
          r  = longint'(sq_od) << 6;
          d2 = (r > e) ? 2 * (r - e) : 2 * (e - r);
          b2 = s_sq + 2 * (longint'(1) << (16 - SQ_MU)) + 2 * (longint'(1) << (16 - SQ_L));
          report(d2 <= b2, "R2 R5", d2, b2);
          if (x == '1) report(sq_od >= 10'd1000, "R6", longint'(sq_od), 1000);
        end
      end
      if (cu_ov && cu_or) begin
        if (q_cu.size() == 0) report(1'b0, "R9", 1, 0);
        else begin
          logic [CU_W-1:0] x;
          longint e;
          x = q_cu.pop_front();
          e = (2 * longint'(x) + 1);
          e = (e * e * e) >> 6;  // R3 R4: exact cube floored to 12 bits
          report(longint'(cu_od) == e, "R3 R4", longint'(cu_od), e);
        end
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    s_sq = 0;
    for (int i = 1; i <= SQ_W + 1; i++)
      for (int j = 1; j <= SQ_W + 1; j++)
        if (i + j > SQ_MU) s_sq += longint'(1) << (16 - i - j);
    rst_n = 1'b0;
    sq_iv = 1'b0; sq_id = '0; cu_iv = 1'b0; cu_id = '0;
    repeat (3) begin
      @(negedge clk); #2;
      report(!sq_ov, "R8", longint'(sq_ov), 0);
    end
    rst_n = 1'b1;
    @(negedge clk); #2;
    report(!sq_ov, "R8", longint'(sq_ov), 0);
    fork
      begin
        send_sq('0);
        send_sq('1);
        for (int x = 0; x < (1 << SQ_W); x++) send_sq(SQ_W'(x));
        @(negedge clk); sq_iv = 1'b0;
      end
      begin
        for (int x = (1 << CU_W) - 1; x >= 0; x--) send_cu(CU_W'(x));
        @(negedge clk); cu_iv = 1'b0;
      end
    join
    repeat (200) begin
      @(negedge clk);
      if (q_sq.size() == 0 && q_cu.size() == 0) break;
    end
    report(q_sq.size() == 0, "R7", q_sq.size(), 0);
    report(q_cu.size() == 0, "R9", q_cu.size(), 0);
    finish_run();
  end
endmodule